// File: doc/BRIEF.md
# Addressed SPI Register-Access Slave

This block sits between a four-wire serial master and a register file. It works in SPI mode 0 and frames each transfer that takes place while chip select is low. The first byte is a selection byte. Its upper nibble must equal a fixed device code. The next three bits are the device's hardware address, and the lowest bit chooses the direction. The second byte names a register. Every later byte is data. On a write, each data byte goes to the register file as a one-cycle strobe. On a read, the block fetches bytes from the register file and shifts them out.

The register file owns the address pointer. The block sends it a one-cycle load pulse carrying the register number. It then sends one write strobe or one read-advance pulse for each completed data byte. Between those pulses the file keeps `rd_data_i` equal to the byte at its current pointer. A transfer can therefore run through any number of consecutive locations until chip select rises. SCK, chip select and MOSI are resynchronised to the system clock. The hardware-address comparison can be switched off by a configuration input, so that devices sharing a select line answer regardless of their pin strapping.

Top module: `spi_reg_slave`

## Requirements
- R1: While chip select is high, and after reset, `spi_miso_oe_o`, `spi_miso_o`, `ptr_load_o`, `wr_strobe_o` and `rd_next_o` are all 0.
- R2: The first byte after chip select falls is accepted when:
  - bits 7:4 equal `0100`, and
  - bits 3:1 equal `dev_pins_i`, or `pin_match_en_i` is 0.
  
  Bit 0 set to 1 selects a read, and 0 selects a write.
- R3: When the first byte is not accepted, the block produces no pulse on any strobe output and keeps `spi_miso_oe_o` at 0 until chip select rises.
- R4: Bytes are received MSB first, with MOSI sampled on rising SCK. After the second byte of an accepted transfer, `ptr_load_o` pulses for one cycle with `ptr_addr_o` equal to that byte.
- R5: In an accepted write, every complete data byte gives exactly one one-cycle `wr_strobe_o` pulse carrying the byte on `wr_data_o`. This continues until chip select rises.
- R6: A data byte that has fewer than eight rising SCK edges when chip select rises produces no write strobe.
- R7: In an accepted read, `rd_data_i` is captured FETCH_LAT cycles after the `ptr_load_o` or `rd_next_o` pulse. The captured byte is shifted out MSB first. MISO changes only after falling SCK edges, and the first bit appears on the falling edge that closes the previous byte. `spi_miso_oe_o` is 1 only during a read.
- R8: In an accepted read, every completed data byte gives one `rd_next_o` pulse. The next byte is then fetched, so a burst streams consecutive locations.
- R9: At most one of `ptr_load_o`, `wr_strobe_o` and `rd_next_o` is high in any cycle. Each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock from the master, idle low |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master; 0 when not driven |
| spi_miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| dev_pins_i | input | 3 | Strapped hardware address |
| pin_match_en_i | input | 1 | 1 enables comparison of the hardware address bits |
| ptr_load_o | output | 1 | Pointer load pulse |
| ptr_addr_o | output | 8 | Register number for the pointer load |
| wr_strobe_o | output | 1 | Write strobe, one per data byte |
| wr_data_o | output | 8 | Write data |
| rd_next_o | output | 1 | Read-advance pulse, one per byte sent |
| rd_data_i | input | 8 | Byte at the register file's current pointer |

## Verification
The embedded properties check, on every cycle:
- the quiet state while chip select is high;
- the silence of a rejected transfer;
- that the strobes are exclusive single-cycle pulses;
- that write strobes occur only in writes and the MISO enable only in reads;
- that MISO changes only after a detected falling SCK edge.

Some behaviour can only be shown by the bench's scenarios, using its own model of a register file with a stepping pointer:
- the acceptance of the selection byte over every combination of strapped pins, received address bits and enable;
- the bit order on both lines;
- the data that streams through bursts, including pointer wrap-around;
- the discarding of a truncated byte.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   typedef enum logic [1:0] {
      PH_SEL  = 2'd0,
      PH_REG  = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } phase_e;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int            STAGES  = 2,
   parameter int            W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad
      $error("spi_slv_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_slv_rx.sv
module spi_slv_rx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              sample_i,
   input  logic              bit_i,
   output logic              done_o,
   output logic [BYTE_W-1:0] byte_o
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (sample_i) begin
         sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
         cnt_q <= (cnt_q == CNT_W'(BYTE_W-1)) ? '0 : cnt_q + 1'b1;
      end
   end

   assign done_o = sample_i && !clear_i && (cnt_q == CNT_W'(BYTE_W-1));
   assign byte_o = {sh_q, bit_i};
endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_val_i,
   input  logic              shift_i,
   output logic              bit_o
);
   logic [BYTE_W-1:0] sh_q;
   logic              out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         out_q <= 1'b0;
      end else if (clear_i) begin
         sh_q  <= '0;
         out_q <= 1'b0;
      end else if (load_i) begin
         sh_q  <= load_val_i;
      end else if (shift_i) begin
         out_q <= sh_q[BYTE_W-1];
         sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign bit_o = out_q;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
   parameter int          CODE_W      = 4,
   parameter int          HWA_W       = 3,
   parameter logic [3:0]  DEV_CODE    = 4'b0100,
   parameter int          SYNC_STAGES = 2,
   parameter int          FETCH_LAT   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spi_sck_i,
   input  logic         spi_csn_i,
   input  logic         spi_mosi_i,
   output logic         spi_miso_o,
   output logic         spi_miso_oe_o,
   input  logic [2:0]   dev_pins_i,
   input  logic         pin_match_en_i,
   output logic         ptr_load_o,
   output logic [7:0]   ptr_addr_o,
   output logic         wr_strobe_o,
   output logic [7:0]   wr_data_o,
   output logic         rd_next_o,
   input  logic [7:0]   rd_data_i
);
   import spi_slv_pkg::*;

   localparam int BYTE_W = CODE_W + HWA_W + 1;

   if (BYTE_W != 8 || CODE_W != 4 || HWA_W != 3) begin : g_bad_fmt
      $error("spi_reg_slave: selection byte must be 4 code + 3 address + 1 direction bits");
   end
   if (FETCH_LAT < 1) begin : g_bad_lat
      $error("spi_reg_slave: FETCH_LAT must be at least 1");
   end

   // input synchronisers: {csn, sck, mosi}
   logic [2:0] sync_q;
   spi_slv_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_csn_i, spi_sck_i, spi_mosi_i}),
      .q_o   (sync_q)
   );

   logic sck_d_q;
   logic cs_act, sck_rise, sck_fall;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d_q <= 1'b0;
      else        sck_d_q <= sync_q[1];
   end
   assign cs_act   = !sync_q[2];
   assign sck_rise = cs_act &&  sync_q[1] && !sck_d_q;
   assign sck_fall = cs_act && !sync_q[1] &&  sck_d_q;

   logic              byte_done;
   logic [BYTE_W-1:0] byte_val;
   spi_slv_rx #(.BYTE_W(BYTE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (!cs_act),
      .sample_i (sck_rise),
      .bit_i    (sync_q[0]),
      .done_o   (byte_done),
      .byte_o   (byte_val)
   );

   phase_e                 phase_q;
   logic                   rnw_q;
   logic                   oe_q;
   logic                   ld_q, wr_q, nx_q;
   logic [BYTE_W-1:0]      addr_q, wdat_q;
   logic [FETCH_LAT-1:0]   pipe_q;
   logic                   fetch_req, tx_load, sel_ok;

   assign sel_ok = (byte_val[BYTE_W-1 -: CODE_W] == DEV_CODE[CODE_W-1:0])
                && (!pin_match_en_i || (byte_val[HWA_W:1] == dev_pins_i));
   assign fetch_req = cs_act && byte_done && rnw_q
                   && (phase_q == PH_REG || phase_q == PH_DATA);
   assign tx_load = cs_act && pipe_q[FETCH_LAT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SEL;
         rnw_q   <= 1'b0;
         oe_q    <= 1'b0;
         ld_q    <= 1'b0;
         wr_q    <= 1'b0;
         nx_q    <= 1'b0;
         addr_q  <= '0;
         wdat_q  <= '0;
         pipe_q  <= '0;
      end else begin
         ld_q   <= 1'b0;
         wr_q   <= 1'b0;
         nx_q   <= 1'b0;
         pipe_q <= FETCH_LAT'({pipe_q, fetch_req});
         if (!cs_act) begin
            phase_q <= PH_SEL;
            oe_q    <= 1'b0;
            pipe_q  <= '0;
         end else begin
            if (tx_load) oe_q <= 1'b1;
            if (byte_done) begin
               unique case (phase_q)
                  PH_SEL: begin
                     phase_q <= sel_ok ? PH_REG : PH_SKIP;
                     rnw_q   <= byte_val[0];
                  end
                  PH_REG: begin
                     ld_q    <= 1'b1;
                     addr_q  <= byte_val;
                     phase_q <= PH_DATA;
                  end
                  PH_DATA: begin
                     if (rnw_q) begin
                        nx_q <= 1'b1;
                     end else begin
                        wr_q   <= 1'b1;
                        wdat_q <= byte_val;
                     end
                  end
                  default: phase_q <= PH_SKIP;
               endcase
            end
         end
      end
   end

   logic tx_bit;
   spi_slv_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (!cs_act),
      .load_i     (tx_load),
      .load_val_i (rd_data_i),
      .shift_i    (sck_fall),
      .bit_o      (tx_bit)
   );

   assign spi_miso_o    = oe_q & tx_bit;
   assign spi_miso_oe_o = oe_q;
   assign ptr_load_o    = ld_q;
   assign ptr_addr_o    = addr_q;
   assign wr_strobe_o   = wr_q;
   assign wr_data_o     = wdat_q;
   assign rd_next_o     = nx_q;

   // R1: deselection leaves every output quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (!spi_miso_oe_o && !spi_miso_o && !ptr_load_o && !wr_strobe_o && !rd_next_o));

   // R3: a rejected transfer stays silent
   p_reject_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SKIP) |-> (!spi_miso_oe_o && !ptr_load_o && !wr_strobe_o && !rd_next_o));

   // R9: strobes are exclusive
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ptr_load_o, wr_strobe_o, rd_next_o}));

   // R9: strobes last one cycle
   p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load_o |=> !ptr_load_o);
   p_next_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_next_o |=> !rd_next_o);

   // R5: write strobes only in a write, as single pulses
   p_wr_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |-> !rnw_q);
   p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |=> !wr_strobe_o);

   // R7: MISO drive only in a read; data moves only after a falling edge
   p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      spi_miso_oe_o |-> rnw_q);
   p_miso_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_miso_oe_o && $past(spi_miso_oe_o) && !$stable(spi_miso_o)) |-> $past(sck_fall));
endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
   logic [2:0] pins = 3'd0;
   logic       men = 1'b0;
   logic       miso, miso_oe, ptr_load, wr_stb, rd_nx;
   logic [7:0] ptr_addr, wr_data, rd_data;

   int checks = 0, errors = 0;
   int n_wr = 0, n_ld = 0, n_nx = 0, n_oe = 0;
   logic [7:0] mem [256];
   logic [7:0] ptr;
   logic [7:0] shadow [256];

   always #10 clk = ~clk;

   spi_reg_slave u0 (
      .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_csn_i(csn), .spi_mosi_i(mosi),
      .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .dev_pins_i(pins), .pin_match_en_i(men),
      .ptr_load_o(ptr_load), .ptr_addr_o(ptr_addr), .wr_strobe_o(wr_stb), .wr_data_o(wr_data),
      .rd_next_o(rd_nx), .rd_data_i(rd_data)
   );

   // register file model with its own stepping pointer
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
         ptr <= 8'd0;
      end else if (ptr_load) begin
         ptr <= ptr_addr;
      end else if (wr_stb) begin
         mem[ptr] <= wr_data;
         ptr <= ptr + 8'd1;
      end else if (rd_nx) begin
         ptr <= ptr + 8'd1;
      end
   end
   assign rd_data = mem[ptr];

   always @(negedge clk) begin
      if (wr_stb)  n_wr++;
      if (ptr_load) n_ld++;
      if (rd_nx)   n_nx++;
      if (miso_oe) n_oe++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r);
      r = 8'h00;
      for (int i = 0; i < nb; i++) begin
         mosi = b[7-i];
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         r = {r[6:0], miso};
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic cs_lo();
      @(negedge clk);
      csn = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (HALF) @(negedge clk);
      csn = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int w0, l0, x0, o0;
      for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 3);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!miso_oe && !miso && !ptr_load && !wr_stb && !rd_nx, "R1", {miso_oe, miso, ptr_load, wr_stb, rd_nx}, 0);

      // R2 R4 R5: sweep of enable, strap and received address bits
      for (int en = 0; en < 2; en++) begin
         for (int pv = 0; pv < 8; pv++) begin
            for (int h = 0; h < 8; h++) begin
               logic [7:0] a, d;
               bit acc;
               men  = en[0];
               pins = pv[2:0];
               a = 8'(en * 64 + pv * 8 + h);
               d = a ^ 8'h5A;
               acc = (en == 0) || (h == pv);
               w0 = n_wr; l0 = n_ld;
               cs_lo();
               xfer({4'b0100, h[2:0], 1'b0}, 8, r);
               xfer(a, 8, r);
               xfer(d, 8, r);
               cs_hi();
               chk((n_wr - w0) == int'(acc) && (n_ld - l0) == int'(acc), "R2",
                   (n_wr - w0) * 16 + (n_ld - l0), int'(acc) * 17);
               if (acc) begin
                  shadow[a] = d;
                  chk(mem[a] == d, "R4", mem[a], d);
               end
               chk(!miso_oe && !wr_stb, "R1", {miso_oe, wr_stb}, 0);
            end
         end
      end

      men = 1'b1; pins = 3'd5;

      // R3: wrong device code, write and read
      w0 = n_wr; l0 = n_ld; o0 = n_oe; x0 = n_nx;
      cs_lo();
      xfer(8'b0101_101_0, 8, r); xfer(8'h20, 8, r); xfer(8'hEE, 8, r);
      cs_hi();
      cs_lo();
      xfer(8'b0110_101_1, 8, r); xfer(8'h20, 8, r); xfer(8'h00, 8, r);
      cs_hi();
      chk(n_wr == w0 && n_ld == l0 && n_oe == o0 && n_nx == x0, "R3",
          (n_wr - w0) + (n_ld - l0) + (n_oe - o0) + (n_nx - x0), 0);
      chk(mem[8'h20] == shadow[8'h20], "R3", mem[8'h20], shadow[8'h20]);
      // R3: read with mismatched strap never drives MISO
      o0 = n_oe;
      cs_lo();
      xfer(8'b0100_011_1, 8, r); xfer(8'h10, 8, r); xfer(8'h00, 8, r);
      cs_hi();
      chk(n_oe == o0, "R3", n_oe - o0, 0);

      // R5: four-byte write burst
      w0 = n_wr;
      cs_lo();
      xfer(8'b0100_101_0, 8, r); xfer(8'h90, 8, r);
      for (int k = 0; k < 4; k++) begin
         xfer(8'(8'hA0 + k * 17), 8, r);
         shadow[8'h90 + k] = 8'(8'hA0 + k * 17);
      end
      cs_hi();
      chk(n_wr - w0 == 4, "R5", n_wr - w0, 4);
      for (int k = 0; k < 4; k++) chk(mem[8'h90 + k] == shadow[8'h90 + k], "R5", mem[8'h90 + k], shadow[8'h90 + k]);

      // R6: truncated second data byte
      w0 = n_wr;
      cs_lo();
      xfer(8'b0100_101_0, 8, r); xfer(8'h80, 8, r); xfer(8'hC3, 8, r); xfer(8'h3C, 5, r);
      cs_hi();
      shadow[8'h80] = 8'hC3;
      chk(n_wr - w0 == 1, "R6", n_wr - w0, 1);
      chk(mem[8'h80] == 8'hC3 && mem[8'h81] == shadow[8'h81], "R6", mem[8'h81], shadow[8'h81]);

      // R7 R8: read burst, MSB first
      x0 = n_nx; o0 = n_oe;
      cs_lo();
      xfer(8'b0100_101_1, 8, r); xfer(8'h90, 8, r);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h00, 8, r);
         chk(r == shadow[8'h90 + k], "R7", r, shadow[8'h90 + k]);
      end
      chk(miso_oe, "R7", miso_oe, 1);
      cs_hi();
      chk(n_nx - x0 == 3, "R8", n_nx - x0, 3);
      chk(n_oe > o0 && !miso_oe, "R7", miso_oe, 0);

      // R8: burst across the pointer wrap, strap check disabled
      men = 1'b0; pins = 3'd0;
      cs_lo();
      xfer(8'b0100_111_1, 8, r); xfer(8'hFE, 8, r);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h00, 8, r);
         chk(r == shadow[8'(8'hFE + k)], "R8", r, shadow[8'(8'hFE + k)]);
      end
      cs_hi();

      // R1 again after everything
      chk(!miso_oe && !miso && !ptr_load && !wr_stb && !rd_nx, "R1", {miso_oe, miso}, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule